// File: doc/BRIEF.md
# Event Header and Trailer Framer

This block puts a fixed envelope of 16-bit words around one event's readout. On an event-start strobe it captures a set of status inputs. These are per-card data-available and trigger-sent flags, the trigger-accept and bunch-crossing counters, the crate and board identity, overlap flags, FIFO status and timeout flags. It then emits eight header words on a valid/ready output stream. Next it forwards payload words from an upstream valid/ready stream unchanged, and once the word flagged as last has been accepted it emits eight trailer words.

Each group of four words carries a 4-bit type marker in bits 15:12. Downstream logic can therefore find its place in the frame from any single word. Some trailer words repeat header content or each other, so a reader can cross-check them. An event with no card data and no trigger-board data produces only a four-word header-only frame, with no payload phase and no trailer.

Top module: `evt_framer`

## Requirements
- R1: After reset, `out_valid` and `pl_ready` are 0 until an event start is accepted.
- R2: Header words 1–4 carry marker 4'b1001. Word 1 holds `{tb_dav, anode_dav, card_lct[4:0], card_dav[4:0]}` in bits 11:0. Words 2 and 3 hold `l1a_cnt[11:0]` and `l1a_cnt[23:12]`, and word 4 holds `bx_cnt[11:0]`.
- R3: Header words 5–8 carry marker 4'b1010. Word 5 holds `{5'b0, tb_dav, anode_dav, card_dav}` and word 6 holds `{crate_id[7:0], board_id[3:0]}`. Word 7 holds `{ovlp[4:0], bx_cnt[6:0]}` and word 8 holds `{sync_cnt[3:0], l1a_cnt[7:0]}`.
- R4: In the payload phase each accepted `pl_data` word appears unchanged on `out_data` in the same cycle. `pl_ready` is high only while `out_ready` is high.
- R5: The payload word accepted with `pl_last` high is the last payload word, and the first trailer word is the next word on the output.
- R6: Trailer words 1–4 carry marker 4'b1111. Word 1 repeats header word 1 bits 11:0, and word 2 holds `{ovlp[4:0], fifo_half_n[6:0]}`. Word 3 holds `{pipe_len[7:0], bx_cnt[3:0]}`, and word 4 repeats the header word 6 identity.
- R7: Trailer words 5–8 carry marker 4'b1110. Word 5 holds `{fifo_nfull[5:0], fifo_nempty[5:0]}`, and words 6, 7 and 8 each hold `tmo_flags[11:0]`.
- R8: When `card_dav` is zero and `tb_dav` is 0 at the accepted start, only four header words are sent, all with marker 4'b1000. The first is exactly 16'h8000, and words 2–4 carry the counters as in R2. No payload is accepted (`pl_ready` stays 0) and no trailer follows.
- R9: All status fields come from the values present at the accepted `evt_start`. Later input changes, and `evt_start` pulses while a frame is in progress, do not alter the frame.
- R10: While a header or trailer word is offered and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Starts a frame; accepted only when idle |
| card_dav | input | 5 | Per-card data-available flags |
| card_lct | input | 5 | Per-card trigger-primitive-sent flags |
| anode_dav | input | 1 | Anode data available |
| tb_dav | input | 1 | Trigger-board data available |
| l1a_cnt | input | 24 | Trigger-accept counter |
| bx_cnt | input | 12 | Bunch-crossing counter |
| crate_id | input | 8 | Crate identity |
| board_id | input | 4 | Board identity |
| ovlp | input | 5 | Per-card multi-overlap flags |
| sync_cnt | input | 4 | Card sync counter |
| fifo_half_n | input | 7 | Active-low half-full flags (five cards, overlap, trigger board) |
| pipe_len | input | 8 | Trigger pipeline length |
| fifo_nempty | input | 6 | Not-empty flags (five cards, trigger board) |
| fifo_nfull | input | 6 | Not-full flags (five cards, trigger board) |
| tmo_flags | input | 12 | Timeouts: 4:0 no card data, 5 no trigger-board data, 10:6 no card end, 11 no anode data |
| pl_data | input | 16 | Payload word |
| pl_valid | input | 1 | Payload word valid |
| pl_last | input | 1 | Marks the final payload word |
| pl_ready | output | 1 | Payload word accepted |
| out_data | output | 16 | Framed output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |

## Verification
The properties assume that the upstream payload source keeps `pl_valid` and `pl_data` steady until they are taken. They also assume that a full frame carries at least one payload word, ending in one marked `pl_last`. The stall-hold property is limited to header and trailer words, because in the payload phase the output simply mirrors upstream. The bench raises a payload word only when none is pending and holds it until `pl_ready`. It marks exactly the final word of each event, and in header-only events it leaves a word pending so that the refusal can be seen. Random back-pressure on `out_ready` exercises stalls in every phase.

// File: rtl/evt_framer.sv
module evt_framer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_start,
  input  logic [4:0]  card_dav,
  input  logic [4:0]  card_lct,
  input  logic        anode_dav,
  input  logic        tb_dav,
  input  logic [23:0] l1a_cnt,
  input  logic [11:0] bx_cnt,
  input  logic [7:0]  crate_id,
  input  logic [3:0]  board_id,
  input  logic [4:0]  ovlp,
  input  logic [3:0]  sync_cnt,
  input  logic [6:0]  fifo_half_n,
  input  logic [7:0]  pipe_len,
  input  logic [5:0]  fifo_nempty,
  input  logic [5:0]  fifo_nfull,
  input  logic [11:0] tmo_flags,
  input  logic [15:0] pl_data,
  input  logic        pl_valid,
  input  logic        pl_last,
  output logic        pl_ready,
  output logic [15:0] out_data,
  output logic        out_valid,
  input  logic        out_ready
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_TRL} state_t;

  state_t      state_q;
  logic [2:0]  idx_q;
  logic        short_q;

  logic [4:0]  dav_q, lct_q, ovlp_q;
  logic        an_q, tb_q;
  logic [23:0] l1a_q;
  logic [11:0] bx_q, tmo_q;
  logic [7:0]  crate_q, pipe_q;
  logic [3:0]  board_q, sync_q;
  logic [6:0]  half_q;
  logic [5:0]  nempty_q, nfull_q;

  logic [15:0] hdr_w, trl_w;
  logic [11:0] sum_w;
  logic [3:0]  mk_lo;
  logic        fire, hdr_end;

  assign sum_w = {tb_q, an_q, lct_q, dav_q};
  assign mk_lo = short_q ? 4'b1000 : 4'b1001;

  always_comb begin
    case (idx_q)
      3'd0:    hdr_w = short_q ? 16'h8000 : {4'b1001, sum_w};
      3'd1:    hdr_w = {mk_lo, l1a_q[11:0]};
      3'd2:    hdr_w = {mk_lo, l1a_q[23:12]};
      3'd3:    hdr_w = {mk_lo, bx_q};
      3'd4:    hdr_w = {4'b1010, 5'b0, tb_q, an_q, dav_q};
      3'd5:    hdr_w = {4'b1010, crate_q, board_q};
      3'd6:    hdr_w = {4'b1010, ovlp_q, bx_q[6:0]};
      default: hdr_w = {4'b1010, sync_q, l1a_q[7:0]};
    endcase
  end

  always_comb begin
    case (idx_q)
      3'd0:    trl_w = {4'b1111, sum_w};
      3'd1:    trl_w = {4'b1111, ovlp_q, half_q};
      3'd2:    trl_w = {4'b1111, pipe_q, bx_q[3:0]};
      3'd3:    trl_w = {4'b1111, crate_q, board_q};
      3'd4:    trl_w = {4'b1110, nfull_q, nempty_q};
      default: trl_w = {4'b1110, tmo_q};
    endcase
  end

  assign out_valid = (state_q == S_HDR) || (state_q == S_TRL) ||
                     ((state_q == S_PAY) && pl_valid);
  assign pl_ready  = (state_q == S_PAY) && out_ready;
  assign out_data  = (state_q == S_HDR) ? hdr_w :
                     (state_q == S_TRL) ? trl_w : pl_data;
  assign fire      = out_valid && out_ready;
  assign hdr_end   = short_q ? (idx_q == 3'd3) : (idx_q == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      short_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (evt_start) begin
          state_q <= S_HDR;
          idx_q   <= '0;
          short_q <= (card_dav == 5'd0) && !tb_dav;
        end
        S_HDR: if (fire) begin
          if (hdr_end) begin
            state_q <= short_q ? S_IDLE : S_PAY;
            idx_q   <= '0;
          end else idx_q <= idx_q + 3'd1;
        end
        S_PAY: if (fire && pl_last) begin
          state_q <= S_TRL;
          idx_q   <= '0;
        end
        default: if (fire) begin
          if (idx_q == 3'd7) state_q <= S_IDLE;
          idx_q <= idx_q + 3'd1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_IDLE && evt_start) begin
      dav_q    <= card_dav;
      lct_q    <= card_lct;
      an_q     <= anode_dav;
      tb_q     <= tb_dav;
      l1a_q    <= l1a_cnt;
      bx_q     <= bx_cnt;
      crate_q  <= crate_id;
      board_q  <= board_id;
      ovlp_q   <= ovlp;
      sync_q   <= sync_cnt;
      half_q   <= fifo_half_n;
      pipe_q   <= pipe_len;
      nempty_q <= fifo_nempty;
      nfull_q  <= fifo_nfull;
      tmo_q    <= tmo_flags;
    end
  end

endmodule

module evt_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  st,
  input logic [2:0]  idx,
  input logic        short_mode,
  input logic [15:0] out_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] pl_data,
  input logic        pl_valid,
  input logic        pl_ready,
  input logic        pl_last
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (!out_valid && !pl_ready));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && st != 2'd2) |=> (out_valid && $stable(out_data)));

  // R4
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> (out_valid && out_ready && out_data == pl_data));

  // R4
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> out_ready);

  // R2
  hdr_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !short_mode) |-> (out_data[15:14] == 2'b10 && out_data[13] != out_data[12]));

  // R8
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && short_mode) |-> (out_data[15:12] == 4'b1000 && idx <= 3'd3 && !pl_ready));

  // R7
  trl_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> (out_data[15:13] == 3'b111));

  // R5
  trl_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && pl_last) |=> (st == 2'd3 && idx == 3'd0));

endmodule

bind evt_framer evt_framer_chk u_evt_framer_chk (
  .clk(clk), .rst_n(rst_n), .st(state_q), .idx(idx_q), .short_mode(short_q),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_last(pl_last)
);

// File: tb/test_evt_framer.sv
module test_evt_framer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_start = 1'b0;
  logic [4:0]  card_dav = '0, card_lct = '0, ovlp = '0;
  logic        anode_dav = 1'b0, tb_dav = 1'b0;
  logic [23:0] l1a_cnt = '0;
  logic [11:0] bx_cnt = '0, tmo_flags = '0;
  logic [7:0]  crate_id = '0, pipe_len = '0;
  logic [3:0]  board_id = '0, sync_cnt = '0;
  logic [6:0]  fifo_half_n = '0;
  logic [5:0]  fifo_nempty = '0, fifo_nfull = '0;
  logic [15:0] pl_data = '0;
  logic        pl_valid = 1'b0, pl_last = 1'b0, out_ready = 1'b0;
  logic        pl_ready, out_valid;
  logic [15:0] out_data;

  always #2.5 clk = ~clk;

  evt_framer i_evt_framer (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start),
    .card_dav(card_dav), .card_lct(card_lct), .anode_dav(anode_dav), .tb_dav(tb_dav),
    .l1a_cnt(l1a_cnt), .bx_cnt(bx_cnt), .crate_id(crate_id), .board_id(board_id),
    .ovlp(ovlp), .sync_cnt(sync_cnt), .fifo_half_n(fifo_half_n), .pipe_len(pipe_len),
    .fifo_nempty(fifo_nempty), .fifo_nfull(fifo_nfull), .tmo_flags(tmo_flags),
    .pl_data(pl_data), .pl_valid(pl_valid), .pl_last(pl_last), .pl_ready(pl_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [4:0]  e_dav, e_lct, e_ovlp;
  logic        e_an, e_tb;
  logic [23:0] e_l1a;
  logic [11:0] e_bx, e_tmo;
  logic [7:0]  e_crate, e_pipe;
  logic [3:0]  e_board, e_sync;
  logic [6:0]  e_half;
  logic [5:0]  e_nempty, e_nfull;
  logic [15:0] exp_w [0:63];
  logic [15:0] pay [0:31];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [11:0] sum12();
    return {e_tb, e_an, e_lct, e_dav};
  endfunction

  task automatic build_exp(input bit short_ev, input int npay);
    logic [3:0] m;
    m = short_ev ? 4'b1000 : 4'b1001;
    exp_w[0] = short_ev ? 16'h8000 : {4'b1001, sum12()};
    exp_w[1] = {m, e_l1a[11:0]};
    exp_w[2] = {m, e_l1a[23:12]};
    exp_w[3] = {m, e_bx};
    if (!short_ev) begin
      exp_w[4] = {4'b1010, 5'b0, e_tb, e_an, e_dav};
      exp_w[5] = {4'b1010, e_crate, e_board};
      exp_w[6] = {4'b1010, e_ovlp, e_bx[6:0]};
      exp_w[7] = {4'b1010, e_sync, e_l1a[7:0]};
      for (int k = 0; k < npay; k++) exp_w[8+k] = pay[k];
      exp_w[8+npay]  = {4'b1111, sum12()};
      exp_w[9+npay]  = {4'b1111, e_ovlp, e_half};
      exp_w[10+npay] = {4'b1111, e_pipe, e_bx[3:0]};
      exp_w[11+npay] = {4'b1111, e_crate, e_board};
      exp_w[12+npay] = {4'b1110, e_nfull, e_nempty};
      exp_w[13+npay] = {4'b1110, e_tmo};
      exp_w[14+npay] = {4'b1110, e_tmo};
      exp_w[15+npay] = {4'b1110, e_tmo};
    end
  endtask

  task automatic scramble();
    card_dav = 5'($urandom); card_lct = 5'($urandom); anode_dav = 1'($urandom);
    tb_dav = 1'($urandom); l1a_cnt = 24'($urandom); bx_cnt = 12'($urandom);
    crate_id = 8'($urandom); board_id = 4'($urandom); ovlp = 5'($urandom);
    sync_cnt = 4'($urandom); fifo_half_n = 7'($urandom); pipe_len = 8'($urandom);
    fifo_nempty = 6'($urandom); fifo_nfull = 6'($urandom); tmo_flags = 12'($urandom);
  endtask

  function automatic string tag_of(input bit short_ev, input int i, input int npay);
    if (short_ev) return "R8";
    if (i < 4) return "R2";
    if (i < 8) return "R3";
    if (i < 8 + npay) return "R4";
    if (i == 8 + npay) return "R5";
    if (i < 12 + npay) return "R6";
    return "R7";
  endfunction

  // mode: 0 random, 1 short, 2 full with trigger board only, 3 all ones
  task automatic run_event(input int mode, input int npay);
    bit short_ev, stalled, consumed;
    logic [15:0] held;
    int got, sent, total;
    @(negedge clk);
    scramble();
    if (mode == 1) begin card_dav = '0; tb_dav = 1'b0; end
    if (mode == 2) begin card_dav = '0; tb_dav = 1'b1; end
    if (mode == 3) begin
      card_dav = '1; card_lct = '1; anode_dav = 1'b1; tb_dav = 1'b1; l1a_cnt = '1;
      bx_cnt = '1; crate_id = '1; board_id = '1; ovlp = '1; sync_cnt = '1;
      fifo_half_n = '1; pipe_len = '1; fifo_nempty = '1; fifo_nfull = '1; tmo_flags = '1;
    end
    short_ev = (card_dav == 5'd0) && !tb_dav;
    e_dav = card_dav; e_lct = card_lct; e_an = anode_dav; e_tb = tb_dav;
    e_l1a = l1a_cnt; e_bx = bx_cnt; e_crate = crate_id; e_board = board_id;
    e_ovlp = ovlp; e_sync = sync_cnt; e_half = fifo_half_n; e_pipe = pipe_len;
    e_nempty = fifo_nempty; e_nfull = fifo_nfull; e_tmo = tmo_flags;
    for (int k = 0; k < npay; k++) pay[k] = 16'($urandom);
    build_exp(short_ev, npay);
    total = short_ev ? 4 : 16 + npay;
    evt_start = 1'b1;
    @(negedge clk);
    evt_start = 1'b0;
    scramble();
    got = 0; sent = 0; stalled = 0; consumed = 0;
    if (short_ev) begin pl_valid = 1'b1; pl_data = 16'($urandom); pl_last = 1'b1; end
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (stalled) begin
        check("R10 hold valid", {15'd0, out_valid}, 16'd1);
        check("R10 hold data", out_data, held);
      end
      if (consumed) begin pl_valid = 1'b0; pl_last = 1'b0; consumed = 0; end
      out_ready = ($urandom % 4) != 0;
      evt_start = (cyc == 3);
      if (!short_ev && !pl_valid && sent < npay && ($urandom % 3) != 0) begin
        pl_valid = 1'b1; pl_data = pay[sent]; pl_last = (sent == npay - 1);
      end
      #1;
      if (short_ev && pl_ready) check("R8 pl_ready", 16'd1, 16'd0);
      if (out_valid && out_ready) begin
        check(tag_of(short_ev, got, npay), out_data, exp_w[got]);
        got++;
      end
      if (pl_valid && pl_ready) begin sent++; consumed = 1; end
      stalled = out_valid && !out_ready && (short_ev || got < 8 || got >= 8 + npay);
      held = out_data;
      if (got == total) break;
    end
    check("R9 word count", 16'(got), 16'(total));
    @(negedge clk);
    pl_valid = 1'b0; pl_last = 1'b0; evt_start = 1'b0;
    #1;
    check(short_ev ? "R8 no trailer" : "R7 frame end", {15'd0, out_valid}, 16'd0);
    check(short_ev ? "R8 no payload taken" : "R1 idle ready", {15'd0, pl_ready}, 16'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R1 reset valid", {15'd0, out_valid}, 16'd0);
    check("R1 reset ready", {15'd0, pl_ready}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 idle valid", {15'd0, out_valid}, 16'd0);
    run_event(1, 0);
    run_event(2, 1);
    run_event(3, 3);
    run_event(0, 1);
    for (int n = 0; n < 40; n++) run_event(($urandom % 6) == 0 ? 1 : 0, 1 + int'($urandom % 20));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule